// File: doc/BRIEF.md
# Key-Protected Sequence Table Register File

This block stores the instruction table that a serial-memory sequencer walks through. The table holds sixteen sequences of four 32-bit words. Software fills the table over a simple synchronous register bus. The sequencer has a read port of its own: it picks a sequence and a word within it, and the stored word appears one clock later.

The table is guarded by a lock. While the lock is closed, writes to table words are dropped without notice, but both the bus and the sequencer can still read. The lock opens or closes only through a two-step exchange. First, a magic value is written to a key register. The next bus write must then go to the lock-control register, and its low two bits say whether to open or close. The lock leaves reset closed. Every change of state needs a fresh key.

Top module: `lut_regfile`

## Requirements
- R1: After reset, `tbl_locked` is 1 and a read of the lock-control register returns 1 in bit 0 and 0 in bit 1.
- R2: The key register is at byte address 0x000, lock-control at 0x004, and the table starts at 0x100. The word for sequence s, word i is at 0x100 + s*16 + i*4. A bus read returns the addressed value on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R3: Writing 0x5AF05AF0 to the key register arms the lock. If the next bus write goes to lock-control with bits [1:0] = 2'b10, the table unlocks. If it carries 2'b01, the table locks. Idle cycles between the two writes do not disarm.
- R4: A lock-control write made while not armed leaves the lock state unchanged.
- R5: Any other bus write between the key write and the command disarms the lock, and the command is then ignored. This covers a key write of a wrong value, a table write and a write to an unmapped address.
- R6: A lock-control write with bits [1:0] equal to 2'b00 or 2'b11 leaves the state unchanged and uses up the armed key.
- R7: Each lock-control write uses up the key. A second command with no new key write is ignored.
- R8: While locked, table writes are dropped. Bus and sequencer reads still return the stored word.
- R9: While unlocked, a table write stores the word, and a bus read of it returns the new value.
- R10: The word selected by `seq_sel` and `seq_word` appears on `seq_data` one cycle later.
- R11: If a table write and a read of the same word fall in the same cycle, the read returns the old value; this holds for both the sequencer port and the bus. Reads in later cycles return the new value.
- R12: A lock-control read returns the locked flag in bit 0, the unlocked flag in bit 1, and zeros elsewhere. A key-register read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| seq_sel | input | 4 | Sequence picked by the sequencer |
| seq_word | input | 2 | Word within the picked sequence |
| seq_data | output | 32 | Table word for the sequencer, one cycle later |
| tbl_locked | output | 1 | 1 while table writes are blocked |

## Verification
A bus write to a table word can land in the same cycle as a read of that same word. The read may come from the sequencer port or from the bus read strobe. The bench provokes both cases by driving the write and the read together, with identical addresses. A scoreboard expects the word held before the write, and then the new word on the next read. A second collision is between a lock command and a table write. The arming order is judged by checking the lock flag after each step of sequences that mix keys, commands, table writes and idle cycles.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam logic [31:0] KEY_VALUE = 32'h5AF0_5AF0;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CTRL  = 2'd1,
    SRC_TABLE = 2'd2
  } rd_src_e;
endpackage

// File: rtl/lut_addr_dec.sv
module lut_addr_dec #(
  parameter int ADDR_W  = 10,
  parameter int DEPTH_W = 6,
  parameter int DEPTH   = 64,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 'h000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h004,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 'h100
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit_key,
  output logic               hit_ctrl,
  output logic               hit_tbl,
  output logic [DEPTH_W-1:0] tbl_index
);
  localparam int TABLE_BYTES = DEPTH * 4;

  logic [ADDR_W-1:0] tbl_ofs;

  always_comb begin
    tbl_ofs   = addr - TABLE_BASE;
    hit_key   = (addr == KEY_ADDR);
    hit_ctrl  = (addr == CTRL_ADDR);
    hit_tbl   = (addr >= TABLE_BASE) && (int'(tbl_ofs) < TABLE_BYTES) && (addr[1:0] == 2'b00);
    tbl_index = DEPTH_W'(tbl_ofs >> 2);
  end
endmodule

// File: rtl/lut_key_guard.sv
module lut_key_guard #(
  parameter int DATA_W     = 32,
  parameter int LOCK_BIT   = 0,
  parameter int UNLOCK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              hit_key,
  input  logic              hit_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  import lut_pkg::*;

  logic armed;
  logic key_ok;

  assign key_ok = (wdata == DATA_W'(KEY_VALUE));

  // Every bus write re-evaluates the armed flag: only a correct key write
  // leaves it set, so any other write in between cancels it.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      locked <= 1'b1;
    end else if (wr) begin
      armed <= hit_key && key_ok;
      if (hit_ctrl && armed) begin
        if (wdata[UNLOCK_BIT] && !wdata[LOCK_BIT])
          locked <= 1'b0;
        else if (wdata[LOCK_BIT] && !wdata[UNLOCK_BIT])
          locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lut_store.sv
module lut_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int NUM_RD = 2
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [AW-1:0]                waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_RD-1:0][AW-1:0]     raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata
);
  // One simple dual-port copy per read port, each inferable as block RAM.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_copy
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we)
        mem[waddr] <= wdata;
      rdata[p] <= mem[raddr[p]];   // read-first on collision
    end
  end
endmodule

// File: rtl/lut_regfile.sv
module lut_regfile #(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 10,
  parameter int NUM_SEQ       = 16,
  parameter int WORDS_PER_SEQ = 4,
  parameter int LOCK_BIT      = 0,
  parameter int UNLOCK_BIT    = 1,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 'h000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h004,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 'h100
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  input  logic [$clog2(NUM_SEQ)-1:0]       seq_sel,
  input  logic [$clog2(WORDS_PER_SEQ)-1:0] seq_word,
  output logic [DATA_W-1:0]                seq_data,
  output logic                             tbl_locked
);
  import lut_pkg::*;

  localparam int DEPTH   = NUM_SEQ * WORDS_PER_SEQ;
  localparam int DEPTH_W = $clog2(DEPTH);
  localparam int PORT_BUS = 0;
  localparam int PORT_SEQ = 1;

  logic               hit_key, hit_ctrl, hit_tbl;
  logic [DEPTH_W-1:0] tbl_index;
  logic               locked;
  logic               tbl_we;
  logic [DATA_W-1:0]  stat_w;
  logic [DATA_W-1:0]  stat_q;
  rd_src_e            src_q;

  logic [1:0][DEPTH_W-1:0] rd_addr;
  logic [1:0][DATA_W-1:0]  rd_data;

  lut_addr_dec #(
    .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .DEPTH(DEPTH),
    .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR), .TABLE_BASE(TABLE_BASE)
  ) u_dec (
    .addr(bus_addr), .hit_key(hit_key), .hit_ctrl(hit_ctrl),
    .hit_tbl(hit_tbl), .tbl_index(tbl_index)
  );

  lut_key_guard #(
    .DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT), .UNLOCK_BIT(UNLOCK_BIT)
  ) u_guard (
    .clk(clk), .rst(rst), .wr(bus_wr), .hit_key(hit_key),
    .hit_ctrl(hit_ctrl), .wdata(bus_wdata), .locked(locked)
  );

  assign tbl_we   = bus_wr && hit_tbl && !locked;
  assign rd_addr[PORT_BUS] = tbl_index;
  assign rd_addr[PORT_SEQ] = {seq_sel, seq_word};

  lut_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(DEPTH_W), .NUM_RD(2)
  ) u_store (
    .clk(clk), .we(tbl_we), .waddr(tbl_index), .wdata(bus_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_comb begin
    stat_w             = '0;
    stat_w[LOCK_BIT]   = locked;
    stat_w[UNLOCK_BIT] = !locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_NONE;
      stat_q <= '0;
    end else begin
      stat_q <= stat_w;
      if (!bus_rd)       src_q <= SRC_NONE;
      else if (hit_ctrl) src_q <= SRC_CTRL;
      else if (hit_tbl)  src_q <= SRC_TABLE;
      else               src_q <= SRC_NONE;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_CTRL:  bus_rdata = stat_q;
      SRC_TABLE: bus_rdata = rd_data[PORT_BUS];
      default:   bus_rdata = '0;
    endcase
  end

  assign seq_data   = rd_data[PORT_SEQ];
  assign tbl_locked = locked;
endmodule

// File: rtl/lut_regfile_chk.sv
module lut_regfile_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 10,
  parameter int LOCK_BIT   = 0,
  parameter int UNLOCK_BIT = 1,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h004
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tbl_locked
);
  import lut_pkg::*;

  logic prev_rst = 1'b0;
  logic key_seen;

  always_ff @(posedge clk) begin
    prev_rst <= rst;
    if (prev_rst && !rst)
      AST_RESET_LOCKED: assert (tbl_locked); // R1
  end

  always_ff @(posedge clk) begin
    if (rst)         key_seen <= 1'b0;
    else if (bus_wr) key_seen <= (bus_addr == KEY_ADDR) && (bus_wdata == DATA_W'(KEY_VALUE));
  end

  AST_NEEDS_ARMED: assert property (@(posedge clk) disable iff (rst)
    !$stable(tbl_locked) |-> $past(key_seen && bus_wr && bus_addr == CTRL_ADDR)); // R4

  AST_UNLOCK_CMD: assert property (@(posedge clk) disable iff (rst)
    $fell(tbl_locked) |-> $past(bus_wdata[UNLOCK_BIT] && !bus_wdata[LOCK_BIT])); // R3

  AST_LOCK_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(tbl_locked) |-> $past(bus_wdata[LOCK_BIT] && !bus_wdata[UNLOCK_BIT])); // R3

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CTRL_ADDR) |=>
      (bus_rdata[LOCK_BIT] == $past(tbl_locked)) && (bus_rdata[UNLOCK_BIT] == !$past(tbl_locked))); // R12
endmodule

bind lut_regfile lut_regfile_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_BIT(LOCK_BIT), .UNLOCK_BIT(UNLOCK_BIT),
  .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (.*);

// File: tb/lut_regfile_tb.sv
module lut_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0]  A_KEY  = 10'h000;
  localparam logic [9:0]  A_CTRL = 10'h004;
  localparam logic [31:0] KEYV   = 32'h5AF0_5AF0;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  seq_sel = '0;
  logic [1:0]  seq_word = '0;
  logic [31:0] seq_data;
  logic        tbl_locked;

  int errors = 0;
  int checks = 0;
  exp_t bq[$];
  exp_t sq[$];
  logic sflag = 1'b0;
  logic brd_d = 1'b0, srd_d = 1'b0;
  exp_t be, se;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_regfile u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_sel(seq_sel),
    .seq_word(seq_word), .seq_data(seq_data), .tbl_locked(tbl_locked)
  );

  function automatic logic [9:0] tbl(input int s, input int i);
    return 10'(10'h100 + s*16 + i*4);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(posedge clk) begin
    brd_d <= bus_rd;
    srd_d <= sflag;
  end

  always @(negedge clk) begin
    if (brd_d) begin
      if (bq.size() == 0) check(1'b0, "bus queue empty", bus_rdata, 32'h0);
      else begin
        be = bq.pop_front();
        check(bus_rdata === be.v, be.tag, bus_rdata, be.v);
      end
    end
    if (srd_d) begin
      if (sq.size() == 0) check(1'b0, "seq queue empty", seq_data, 32'h0);
      else begin
        se = sq.pop_front();
        check(seq_data === se.v, se.tag, seq_data, se.v);
      end
    end
  end

  task automatic bwrite(input logic [9:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [9:0] a, input logic [31:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    bq.push_back('{v: e, tag: tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic sread(input int s, input int i, input logic [31:0] e, input string tag);
    seq_sel = 4'(s); seq_word = 2'(i); sflag = 1'b1;
    sq.push_back('{v: e, tag: tag});
    @(negedge clk);
    sflag = 1'b0;
  endtask

  task automatic wr_sread(input int s, input int i, input logic [31:0] d,
                          input logic [31:0] e, input string tag);
    bus_wr = 1'b1; bus_addr = tbl(s, i); bus_wdata = d;
    seq_sel = 4'(s); seq_word = 2'(i); sflag = 1'b1;
    sq.push_back('{v: e, tag: tag});
    @(negedge clk);
    bus_wr = 1'b0; sflag = 1'b0;
  endtask

  task automatic wr_bread(input logic [9:0] a, input logic [31:0] d,
                          input logic [31:0] e, input string tag);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = a; bus_wdata = d;
    bq.push_back('{v: e, tag: tag});
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic chk_lock(input logic e, input string tag);
    check(tbl_locked === e, tag, {31'b0, tbl_locked}, {31'b0, e});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_lock(1'b1, "R1 locked after reset");
    bread(A_CTRL, 32'h1, "R1 R12 ctrl read after reset");
    bread(A_KEY, 32'h0, "R12 key reads zero");

    bwrite(A_CTRL, 32'h2);
    chk_lock(1'b1, "R4 unlock without key ignored");

    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h2);
    chk_lock(1'b0, "R3 unlock after key");
    bread(A_CTRL, 32'h2, "R12 ctrl read unlocked");

    bwrite(tbl(0, 0), 32'hA000_0000);
    bwrite(tbl(0, 1), 32'hA000_0001);
    bwrite(tbl(5, 2), 32'h5200_0052);
    bwrite(tbl(15, 3), 32'hF300_00F3);
    bread(tbl(0, 0), 32'hA000_0000, "R9 R2 read s0 w0");
    bread(tbl(0, 1), 32'hA000_0001, "R9 R2 read s0 w1");
    bread(tbl(15, 3), 32'hF300_00F3, "R9 R2 read s15 w3");
    sread(15, 3, 32'hF300_00F3, "R10 seq s15 w3");
    sread(5, 2, 32'h5200_0052, "R10 seq s5 w2");
    sread(0, 1, 32'hA000_0001, "R10 seq s0 w1");

    bwrite(A_KEY, KEYV);
    repeat (3) @(negedge clk);
    bwrite(A_CTRL, 32'h1);
    chk_lock(1'b1, "R3 lock after key with idle gap");

    bwrite(tbl(5, 2), 32'hDEAD_BEEF);
    bread(tbl(5, 2), 32'h5200_0052, "R8 locked write dropped bus");
    sread(5, 2, 32'h5200_0052, "R8 locked write dropped seq");

    bwrite(A_KEY, KEYV); bwrite(tbl(0, 0), 32'h1111_1111); bwrite(A_CTRL, 32'h2);
    chk_lock(1'b1, "R5 table write disarms");
    bread(tbl(0, 0), 32'hA000_0000, "R8 locked table write while armed dropped");
    bwrite(A_KEY, KEYV); bwrite(A_KEY, 32'h5AF0_5AF1); bwrite(A_CTRL, 32'h2);
    chk_lock(1'b1, "R5 wrong key disarms");
    bwrite(A_KEY, KEYV); bwrite(10'h008, 32'h0); bwrite(A_CTRL, 32'h2);
    chk_lock(1'b1, "R5 unmapped write disarms");

    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h3);
    chk_lock(1'b1, "R6 both bits no change");
    bwrite(A_CTRL, 32'h2);
    chk_lock(1'b1, "R6 key consumed by both-bits command");
    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h0);
    chk_lock(1'b1, "R6 no bits no change");
    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h2);
    chk_lock(1'b0, "R3 unlock again");
    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h0);
    chk_lock(1'b0, "R6 no bits keeps unlocked");
    bwrite(A_CTRL, 32'h1);
    chk_lock(1'b0, "R6 R7 lock without fresh key ignored");
    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h2); bwrite(A_CTRL, 32'h1);
    chk_lock(1'b0, "R7 second command needs new key");

    wr_sread(15, 3, 32'h0BAD_F00D, 32'hF300_00F3, "R11 seq collision old value");
    sread(15, 3, 32'h0BAD_F00D, "R11 seq next read new value");
    wr_bread(tbl(0, 0), 32'hB000_0000, 32'hA000_0000, "R11 bus collision old value");
    bread(tbl(0, 0), 32'hB000_0000, "R11 bus next read new value");

    bwrite(A_KEY, KEYV); bwrite(A_CTRL, 32'h1);
    chk_lock(1'b1, "R3 relock");
    bread(A_CTRL, 32'h1, "R12 ctrl read locked");

    repeat (3) @(negedge clk);
    check(bq.size() == 0 && sq.size() == 0, "R2 all reads answered",
          32'(bq.size() + sq.size()), 32'h0);
    finish_run();
  end
endmodule